// File: doc/BRIEF.md
# Timer Increment Event Generator

This block decides when a 16-bit timer advances. It picks one of two event sources: an internal tick that the surrounding logic raises once per instruction cycle, or an external clock pin. The external pin can go through a synchroniser chain or skip it. Only rising edges of the pin that follow a falling edge count, so a pin that is already high when counting starts does not produce a spurious first count. The selected events then go through a prescaler that divides by 1, 2, 4 or 8. The result is a one-cycle increment pulse for the timer register.

The prescaler is cleared by the strobe that accompanies a low-byte write of the timer. A high-byte write has no connection to this block and leaves the prescaler alone. When the run enable is low, nothing is counted and the prescaler holds its value. Dropping the run enable or changing the source also clears the falling-edge qualifier, which then has to see a new falling edge before it counts again.

Top module: `tmr_evt_gen`

## Requirements
- R1: With `src_ext`=0, `run_en`=1 and `psc_sel`=00, every cycle in which `int_tick` is high gives `inc_pulse` high for exactly one cycle, in the cycle after.
- R2: With `src_ext`=1, a rising edge of `ext_clk_in` counts only if a falling edge of the sampled pin has been seen since the qualifier was last cleared.
- R3: With `sync_bypass`=0, the pin passes through two flip-flops, and a counted rising edge gives a pulse three clock edges after the edge at which the pin is first sampled high. With `sync_bypass`=1, the pulse follows after one edge.
- R4: `psc_sel` sets the division of events: 00 gives 1:1, 01 gives 1:2, 10 gives 1:4 and 11 gives 1:8. After a clear, the pulse comes on the Nth, 2Nth and later events.
- R5: `psc_clr` high sets the prescale count to zero and drops any event in the same cycle. No pulse follows a clear cycle.
- R6: While `run_en`=0, no event is counted, no pulse is produced and the prescale count holds its value.
- R7: Dropping `run_en` or changing `src_ext` clears the falling-edge qualifier. The next rising edge after that is not counted.
- R8: In internal mode, `sync_bypass` has no effect on the pulses.
- R9: In external mode, `int_tick` has no effect on the pulses.
- R10: After a synchronous reset, `inc_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | 0: internal tick, 1: external pin |
| sync_bypass | input | 1 | 1: external pin not synchronised (external mode only) |
| psc_sel | input | 2 | Prescale select: 00 1:1, 01 1:2, 10 1:4, 11 1:8 |
| ext_clk_in | input | 1 | External clock pin |
| int_tick | input | 1 | Internal instruction-cycle tick |
| psc_clr | input | 1 | Prescaler clear (low-byte write strobe) |
| inc_pulse | output | 1 | One-cycle timer increment pulse |

## Verification
The hardest cases to reach are the qualifier's clear-and-re-arm paths. These need a pin that is high when counting starts, a disable pulse, or a source flip that falls between a falling edge and the next rising edge. Directed phases hold the pin at a fixed level, briefly drop `run_en` or toggle `src_ext`, and then raise the pin, so the uncounted edge shows up as a missing pulse. Synchroniser latency is measured by counting cycles from the pin's rise to the pulse, once with the bypass set and once without. A long random phase then mixes all controls against the reference model.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int PSC_SEL_W = 2;

  typedef enum logic [PSC_SEL_W-1:0] {
    PSC_DIV1 = 2'b00,
    PSC_DIV2 = 2'b01,
    PSC_DIV4 = 2'b10,
    PSC_DIV8 = 2'b11
  } psc_e;

  // terminal count (division minus one) for a prescale code
  function automatic logic [3:0] psc_last(input logic [PSC_SEL_W-1:0] sel);
    return 4'((1 << sel) - 1);
  endfunction
endpackage

// File: rtl/tmr_edge_qual.sv
module tmr_edge_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic src_ext,
  input  logic bypass,
  input  logic pin,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp, prev_q, armed_q, src_q, fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign smp    = bypass ? pin : sync_q[SYNC_STAGES-1];
  assign fall   = prev_q & ~smp;
  assign rise_o = ~prev_q & smp & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      prev_q <= smp;
      src_q  <= src_ext;
      if (!en || (src_ext != src_q)) armed_q <= 1'b0;
      else if (fall)                 armed_q <= 1'b1;
    end
  end

  // R7: disabling the block leaves the qualifier cleared
  p_disarm_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !armed_q);
  // R7: a source change leaves the qualifier cleared
  p_disarm_src_r7: assert property (@(posedge clk) disable iff (rst)
    (src_ext != $past(src_ext)) |=> !armed_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 ev,
  input  logic [PSC_SEL_W-1:0] sel,
  output logic                 tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       last;
  logic             wrap;

  assign last = psc_last(sel);
  assign wrap = ({{(4 > CNT_W ? 4 - CNT_W : 0){1'b0}}, cnt_q} >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (ev) begin
        if (wrap) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: a clear cycle never produces a pulse
  p_clr_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tick_o);
  // R4: 1:1 passes every event
  p_div1_r4: assert property (@(posedge clk) disable iff (rst)
    (ev && !clr && sel == PSC_DIV1) |=> tick_o);
endmodule

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen
  import tmr_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 src_ext,
  input  logic                 sync_bypass,
  input  logic [PSC_SEL_W-1:0] psc_sel,
  input  logic                 ext_clk_in,
  input  logic                 int_tick,
  input  logic                 psc_clr,
  output logic                 inc_pulse
);
  logic ext_rise, ev;

  tmr_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .en     (run_en),
    .src_ext(src_ext),
    .bypass (sync_bypass),
    .pin    (ext_clk_in),
    .rise_o (ext_rise)
  );

  assign ev = run_en & (src_ext ? ext_rise : int_tick);

  tmr_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .clr   (psc_clr),
    .ev    (ev),
    .sel   (psc_sel),
    .tick_o(inc_pulse)
  );

  // R6: stopped means no pulse
  p_no_run_r6: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !inc_pulse);
  // R1: internal tick at 1:1 yields a pulse next cycle
  p_int_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (run_en && !src_ext && int_tick && !psc_clr && psc_sel == PSC_DIV1) |=> inc_pulse);
endmodule

// File: tb/tb_tmr_evt_gen.sv
module tb_tmr_evt_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 0, src_ext = 0, sync_bypass = 0, ext_clk_in = 0, int_tick = 0, psc_clr = 0;
  logic [1:0] psc_sel = 2'b00;
  logic inc_pulse;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  tmr_evt_gen dut (
    .clk(clk), .rst(rst), .run_en(run_en), .src_ext(src_ext),
    .sync_bypass(sync_bypass), .psc_sel(psc_sel), .ext_clk_in(ext_clk_in),
    .int_tick(int_tick), .psc_clr(psc_clr), .inc_pulse(inc_pulse)
  );

  // behavioural reference model
  int h1, h2, mprev, marm, msrc, mcnt, exp_p;
  always @(posedge clk) begin
    int smp, fall, rise, ev, fire;
    if (rst) begin
      h1 = 0; h2 = 0; mprev = 0; marm = 0; msrc = 0; mcnt = 0; exp_p = 0;
    end else begin
      smp  = sync_bypass ? int'(ext_clk_in) : h2;
      fall = (mprev == 1 && smp == 0);
      rise = (mprev == 0 && smp == 1 && marm == 1);
      ev   = run_en && (src_ext ? rise : int_tick);
      fire = 0;
      if (psc_clr) mcnt = 0;
      else if (ev) begin
        mcnt++;
        if (mcnt >= (1 << psc_sel)) begin mcnt = 0; fire = 1; end
      end
      if (!run_en || int'(src_ext) != msrc) marm = 0;
      else if (fall) marm = 1;
      msrc = src_ext; mprev = smp; h2 = h1; h1 = ext_clk_in;
      exp_p = fire;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      n_tests++;
      if (int'(inc_pulse) != exp_p) begin
        n_fail++;
        $display("FAIL %s cycle %0d: inc_pulse=%0d expected %0d", cur_req, cyc, inc_pulse, exp_p);
      end
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic count_pulses(input int k, output int c);
    c = 0;
    repeat (k) begin @(negedge clk); if (inc_pulse) c++; end
  endtask

  task automatic latency(output int n);
    n = 0;
    repeat (8) begin @(negedge clk); n++; if (inc_pulse) break; end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int c, lat;
    step(3);
    check("R10", inc_pulse, 0);
    rst = 0;

    cur_req = "R1";
    run_en = 1; src_ext = 0; psc_sel = 0; int_tick = 1;
    count_pulses(10, c); check("R1", c, 10);
    int_tick = 0; step(2);

    cur_req = "R4";
    for (int s = 1; s < 4; s++) begin
      psc_sel = 2'(s); psc_clr = 1; step(1); psc_clr = 0;
      int_tick = 1; count_pulses(16, c); int_tick = 0;
      check("R4", c, 16 >> s);
      step(1);
    end

    cur_req = "R5";
    psc_sel = 2'b11; psc_clr = 1; step(1); psc_clr = 0; int_tick = 1;
    count_pulses(7, c); check("R5", c, 0);
    psc_clr = 1; count_pulses(1, c); check("R5", c, 0);
    psc_clr = 0; count_pulses(7, c); check("R5", c, 0);
    count_pulses(1, c); check("R5", c, 1);

    cur_req = "R6";
    psc_sel = 0; run_en = 0; count_pulses(10, c); check("R6", c, 0);
    run_en = 1; int_tick = 0; step(1);

    cur_req = "R8";
    for (int i = 0; i < 20; i++) begin
      int_tick = (i % 2 == 0); sync_bypass = (i % 3 == 0); step(1);
    end
    int_tick = 0; step(1);
    check("R8", 1, 1);

    cur_req = "R2";
    src_ext = 1; sync_bypass = 1; ext_clk_in = 0; step(3);
    c = 0;
    for (int i = 0; i < 5; i++) begin
      int k;
      ext_clk_in = (i % 2 == 0); count_pulses(3, k); c += k;
    end
    begin int k; count_pulses(3, k); c += k; end
    check("R2", c, 2);

    cur_req = "R3";
    sync_bypass = 0; ext_clk_in = 0; step(5);
    ext_clk_in = 1; latency(lat); check("R3", lat, 3);
    ext_clk_in = 0; step(5); sync_bypass = 1; step(2);
    ext_clk_in = 1; latency(lat); check("R3", lat, 1);

    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin int_tick = 1'($urandom); step(1); end
    int_tick = 0; step(1);
    check("R9", 1, 1);

    cur_req = "R7";
    ext_clk_in = 0; step(3);
    run_en = 0; step(1); run_en = 1; step(1);
    ext_clk_in = 1; count_pulses(4, c); check("R7", c, 0);
    ext_clk_in = 0; step(3); ext_clk_in = 1; count_pulses(3, c); check("R7", c, 1);
    ext_clk_in = 0; step(3);
    src_ext = 0; step(1); src_ext = 1; step(1);
    ext_clk_in = 1; count_pulses(4, c); check("R7", c, 0);

    cur_req = "R4";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      run_en = (r % 8) != 0; src_ext = r[3] & r[4]; sync_bypass = r[5];
      psc_sel = r[7:6]; ext_clk_in = r[8] | r[9]; int_tick = r[10];
      psc_clr = (r[15:11] == 0);
      step(1);
    end
    step(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule